// File: doc/BRIEF.md
# Time-of-day watch with programmable alarm

This block keeps the time of day as hours, minutes and seconds. Each pulse on a one-second tick input moves it forward by one second, carrying from seconds into minutes and from minutes into hours. A second register set holds an alarm time. When a tick moves the watch onto the alarm time, and the alarm is armed, the block emits a single-cycle alarm event. That event is meant to set the timer-alarm flag in a neighbouring status register.

A host reaches all six time fields through a simple port. Writes take effect on the next clock edge. Reads return registered data one clock after the address is presented. The alarm fields take any value their width allows. The alarm is armed only while the programmed time is no later than 24:00:00, so an out-of-range alarm setting switches the function off. The reset values are picked to leave the alarm disarmed.

Top module: `tod_watch_alarm`

## Requirements
- R1: While `rst` is high at a clock edge, the watch is set to 00:00:00 and the alarm to hours 31, minutes 63, seconds 63. At that edge `rd_data`, `alarm_pulse` and `alarm_armed` go to 0.
- R2: The register map is: address 0 watch seconds, 1 watch minutes, 2 watch hours, 3 alarm seconds, 4 alarm minutes, 5 alarm hours. Addresses 6 and 7 read as 0, and unused upper data bits read as 0. `rd_data` shows the addressed field one clock after `rd_addr` is presented.
- R3: A tick adds one to the seconds. When seconds are at 59, a tick sets them to 0 and adds one to the minutes.
- R4: A carry into minutes at 59 sets them to 0 and carries into hours. A carry into hours at 23 sets them to 0, so 23:59:59 becomes 00:00:00 on one tick.
- R5: A watch write stores the low bits of `wr_data` (5 bits for hours, 6 bits for minutes and seconds). A field written at or above its last value (59 or 23) goes to 0 and carries on its next step.
- R6: An alarm write stores the low bits of `wr_data` (5 bits for hours, 6 bits for minutes and seconds), so the full ranges 0..31 and 0..63 can be held.
- R7: `alarm_armed` is 1 exactly when the alarm time is no later than 24:00:00, that is, when hours are below 24 or the setting is exactly 24:00:00. It follows the alarm registers one clock after they change, and it is 0 at the reset defaults.
- R8: `alarm_pulse` is high for exactly one clock, in the cycle that follows the tick edge which moves the watch onto an armed alarm time. A match while the alarm is disarmed gives no pulse.
- R9: If a watch write and a tick occur in the same cycle, the write is applied and the tick is dropped for all three fields. That cycle produces no alarm pulse.
- R10: Writing the watch directly to a value equal to the alarm time does not produce an alarm pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-second advance strobe, one clock wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Registered read data |
| tod_hr | output | 5 | Current watch hours |
| tod_min | output | 6 | Current watch minutes |
| tod_sec | output | 6 | Current watch seconds |
| alarm_armed | output | 1 | Alarm setting is within range |
| alarm_pulse | output | 1 | Single-cycle alarm event |

## Verification
A wrong carry or rollover shows on the `tod_*` ports right after the tick edge that crosses the boundary. A wrong stored value shows on `rd_data` one clock after that field is addressed. A faulty armed decode or a faulty match shows as a missing or extra `alarm_pulse` in the cycle after the matching tick, and a faulty armed decode also shows on `alarm_armed` one clock after the alarm write. A broken write-over-tick priority shows straight away as a watch value one second off, or as a pulse with no tick behind it.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int SEC_W_DEF   = 6;
  localparam int MIN_W_DEF   = 6;
  localparam int HR_W_DEF    = 5;
  localparam int SEC_LAST_DEF = 59;
  localparam int MIN_LAST_DEF = 59;
  localparam int HR_LAST_DEF  = 23;
  localparam int ARM_HR_DEF   = 24;
  localparam int NUM_FIELDS   = 6;

  typedef enum logic [2:0] {
    REG_WSEC = 3'd0,
    REG_WMIN = 3'd1,
    REG_WHR  = 3'd2,
    REG_ASEC = 3'd3,
    REG_AMIN = 3'd4,
    REG_AHR  = 3'd5
  } tod_reg_e;
endpackage

// File: rtl/tod_digit.sv
module tod_digit #(
  parameter int W    = 6,
  parameter int LAST = 59
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  input  logic         step,
  output logic [W-1:0] val,
  output logic [W-1:0] nxt_step,
  output logic         carry
);
  localparam logic [W-1:0] LAST_V = W'(LAST);

  logic at_end;
  assign at_end   = (val >= LAST_V);
  assign carry    = step && at_end;
  assign nxt_step = step ? (at_end ? '0 : val + 1'b1) : val;

  always_ff @(posedge clk) begin
    if (rst)        val <= '0;
    else if (wr_en) val <= wr_val;
    else if (step)  val <= nxt_step;
  end

  // R3
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !wr_en && at_end) |=> (val == '0));
  // R4
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!step && !wr_en) |=> $stable(val));
endmodule

// File: rtl/tod_alarm.sv
module tod_alarm #(
  parameter int SEC_W  = 6,
  parameter int MIN_W  = 6,
  parameter int HR_W   = 5,
  parameter int ARM_HR = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_sec,
  input  logic             wr_min,
  input  logic             wr_hr,
  input  logic [SEC_W-1:0] wd_sec,
  input  logic [MIN_W-1:0] wd_min,
  input  logic [HR_W-1:0]  wd_hr,
  input  logic             cand,
  input  logic [SEC_W-1:0] nx_sec,
  input  logic [MIN_W-1:0] nx_min,
  input  logic [HR_W-1:0]  nx_hr,
  output logic [SEC_W-1:0] al_sec,
  output logic [MIN_W-1:0] al_min,
  output logic [HR_W-1:0]  al_hr,
  output logic             armed_o,
  output logic             pulse_o
);
  localparam logic [HR_W-1:0] ARM_HR_V = HR_W'(ARM_HR);

  logic armed_c, match_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      al_sec <= '1;
      al_min <= '1;
      al_hr  <= '1;
    end else begin
      if (wr_sec) al_sec <= wd_sec;
      if (wr_min) al_min <= wd_min;
      if (wr_hr)  al_hr  <= wd_hr;
    end
  end

  assign armed_c = (al_hr < ARM_HR_V) ||
                   ((al_hr == ARM_HR_V) && (al_min == '0) && (al_sec == '0));
  assign match_c = (nx_sec == al_sec) && (nx_min == al_min) && (nx_hr == al_hr);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_o <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      armed_o <= armed_c;
      pulse_o <= cand && armed_c && match_c;
    end
  end

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);
  // R7
  over_range_hr_chk: assert property (@(posedge clk) disable iff (rst)
    (al_hr > ARM_HR_V) |=> !armed_o);
  // R8
  pulse_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> $past(cand));
endmodule

// File: rtl/tod_regmux.sv
module tod_regmux #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int NREG   = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      rd_addr,
  input  logic [NREG*DATA_W-1:0] fields,
  output logic [DATA_W-1:0]      rd_data
);
  localparam int NSLOT = 1 << ADDR_W;

  logic [DATA_W-1:0] slot [NSLOT];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    if (i < NREG) begin : g_map
      assign slot[i] = fields[i*DATA_W +: DATA_W];
    end else begin : g_zero
      assign slot[i] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= slot[rd_addr];
  end

  // R2
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(rd_addr) >= NREG) |=> (rd_data == '0));
endmodule

// File: rtl/tod_watch_alarm.sv
module tod_watch_alarm
  import tod_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 8,
  parameter int SEC_W    = SEC_W_DEF,
  parameter int MIN_W    = MIN_W_DEF,
  parameter int HR_W     = HR_W_DEF,
  parameter int SEC_LAST = SEC_LAST_DEF,
  parameter int MIN_LAST = MIN_LAST_DEF,
  parameter int HR_LAST  = HR_LAST_DEF,
  parameter int ARM_HR   = ARM_HR_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [HR_W-1:0]   tod_hr,
  output logic [MIN_W-1:0]  tod_min,
  output logic [SEC_W-1:0]  tod_sec,
  output logic              alarm_armed,
  output logic              alarm_pulse
);
  localparam int NREG = NUM_FIELDS;

  logic ws_we, wm_we, wh_we, as_we, am_we, ah_we;
  logic watch_wr, tick_eff;
  logic c_sec, c_min, c_hr;
  logic [SEC_W-1:0] nx_sec, al_sec;
  logic [MIN_W-1:0] nx_min, al_min;
  logic [HR_W-1:0]  nx_hr, al_hr;
  logic [NREG*DATA_W-1:0] fields;

  assign ws_we = wr_en && (wr_addr == ADDR_W'(REG_WSEC));
  assign wm_we = wr_en && (wr_addr == ADDR_W'(REG_WMIN));
  assign wh_we = wr_en && (wr_addr == ADDR_W'(REG_WHR));
  assign as_we = wr_en && (wr_addr == ADDR_W'(REG_ASEC));
  assign am_we = wr_en && (wr_addr == ADDR_W'(REG_AMIN));
  assign ah_we = wr_en && (wr_addr == ADDR_W'(REG_AHR));

  assign watch_wr = ws_we || wm_we || wh_we;
  assign tick_eff = tick && !watch_wr;

  tod_digit #(.W(SEC_W), .LAST(SEC_LAST)) u_sec (
    .clk(clk), .rst(rst), .wr_en(ws_we), .wr_val(wr_data[SEC_W-1:0]),
    .step(tick_eff), .val(tod_sec), .nxt_step(nx_sec), .carry(c_sec));

  tod_digit #(.W(MIN_W), .LAST(MIN_LAST)) u_min (
    .clk(clk), .rst(rst), .wr_en(wm_we), .wr_val(wr_data[MIN_W-1:0]),
    .step(c_sec), .val(tod_min), .nxt_step(nx_min), .carry(c_min));

  tod_digit #(.W(HR_W), .LAST(HR_LAST)) u_hr (
    .clk(clk), .rst(rst), .wr_en(wh_we), .wr_val(wr_data[HR_W-1:0]),
    .step(c_min), .val(tod_hr), .nxt_step(nx_hr), .carry(c_hr));

  tod_alarm #(.SEC_W(SEC_W), .MIN_W(MIN_W), .HR_W(HR_W), .ARM_HR(ARM_HR)) u_alarm (
    .clk(clk), .rst(rst),
    .wr_sec(as_we), .wr_min(am_we), .wr_hr(ah_we),
    .wd_sec(wr_data[SEC_W-1:0]), .wd_min(wr_data[MIN_W-1:0]), .wd_hr(wr_data[HR_W-1:0]),
    .cand(tick_eff), .nx_sec(nx_sec), .nx_min(nx_min), .nx_hr(nx_hr),
    .al_sec(al_sec), .al_min(al_min), .al_hr(al_hr),
    .armed_o(alarm_armed), .pulse_o(alarm_pulse));

  assign fields[0*DATA_W +: DATA_W] = DATA_W'(tod_sec);
  assign fields[1*DATA_W +: DATA_W] = DATA_W'(tod_min);
  assign fields[2*DATA_W +: DATA_W] = DATA_W'(tod_hr);
  assign fields[3*DATA_W +: DATA_W] = DATA_W'(al_sec);
  assign fields[4*DATA_W +: DATA_W] = DATA_W'(al_min);
  assign fields[5*DATA_W +: DATA_W] = DATA_W'(al_hr);

  tod_regmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG)) u_rd (
    .clk(clk), .rst(rst), .rd_addr(rd_addr), .fields(fields), .rd_data(rd_data));

  // R9
  write_beats_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $past(watch_wr) |-> !alarm_pulse);
  // R8
  pulse_on_equal_chk: assert property (@(posedge clk) disable iff (rst)
    (alarm_pulse && !$past(as_we || am_we || ah_we)) |->
      (tod_sec == al_sec && tod_min == al_min && tod_hr == al_hr));
  // R4
  hour_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (c_hr && !wh_we) |=> (tod_hr == '0));
endmodule

// File: tb/tb_tod_watch_alarm.sv
module tb_tod_watch_alarm;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [4:0] tod_hr;
  logic [5:0] tod_min, tod_sec;
  logic       alarm_armed, alarm_pulse;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tod_watch_alarm dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .tod_hr(tod_hr), .tod_min(tod_min), .tod_sec(tod_sec),
    .alarm_armed(alarm_armed), .alarm_pulse(alarm_pulse));

  localparam logic [1:0] OP_WR = 2'd1, OP_RD = 2'd2, OP_TK = 2'd3;
  // {op, addr, data, expected}
  localparam logic [20:0] VEC [21] = '{
    {OP_WR, 3'd0, 8'd57,  8'd0},
    {OP_RD, 3'd0, 8'd0,   8'd57},
    {OP_TK, 3'd0, 8'd2,   8'd0},
    {OP_RD, 3'd0, 8'd0,   8'd59},
    {OP_TK, 3'd0, 8'd1,   8'd0},
    {OP_RD, 3'd0, 8'd0,   8'd0},
    {OP_RD, 3'd1, 8'd0,   8'd1},
    {OP_WR, 3'd2, 8'hFF,  8'd0},
    {OP_RD, 3'd2, 8'd0,   8'd31},
    {OP_TK, 3'd0, 8'd1,   8'd0},
    {OP_RD, 3'd2, 8'd0,   8'd31},
    {OP_RD, 3'd0, 8'd0,   8'd1},
    {OP_WR, 3'd3, 8'hC5,  8'd0},
    {OP_RD, 3'd3, 8'd0,   8'd5},
    {OP_WR, 3'd4, 8'h7F,  8'd0},
    {OP_RD, 3'd4, 8'd0,   8'd63},
    {OP_WR, 3'd5, 8'hE0,  8'd0},
    {OP_RD, 3'd5, 8'd0,   8'd0},
    {OP_RD, 3'd6, 8'd0,   8'd0},
    {OP_RD, 3'd7, 8'd0,   8'd0},
    {OP_RD, 3'd1, 8'd0,   8'd1}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; tick = 1'b0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input int exp, input string req);
    rd_addr = a;
    @(negedge clk);
    check(req, rd_data, exp);
  endtask

  task automatic tk(input int exp_pulse, input string req);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    check(req, alarm_pulse, exp_pulse);
  endtask

  task automatic set_watch(input int h, input int m, input int s);
    wr(3'd2, 8'(h)); wr(3'd1, 8'(m)); wr(3'd0, 8'(s));
  endtask

  task automatic chk_time(input string req, input int h, input int m, input int s);
    check(req, tod_hr, h); check(req, tod_min, m); check(req, tod_sec, s);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    chk_time("R1 watch", 0, 0, 0);
    check("R1 rd_data", rd_data, 0);
    check("R1 pulse", alarm_pulse, 0);
    check("R1 armed", alarm_armed, 0);
    rd(3'd3, 63, "R1 alarm sec");
    rd(3'd4, 63, "R1 alarm min");
    rd(3'd5, 31, "R1 alarm hr");
    check("R7 disarmed at defaults", alarm_armed, 0);

    // Table walk: R2 map, R3 seconds carry, R5 and R6 masking
    do_reset();
    foreach (VEC[i]) begin
      case (VEC[i][20:19])
        OP_WR: wr(VEC[i][18:16], VEC[i][15:8]);
        OP_RD: rd(VEC[i][18:16], VEC[i][7:0], "R2/R3/R5/R6 table");
        OP_TK: for (int n = 0; n < int'(VEC[i][15:8]); n++) tk(0, "R8 no pulse in table");
        default: ;
      endcase
    end

    // R4 full-day rollover and hour carry
    set_watch(23, 59, 59);
    tk(0, "R4 rollover pulse");
    chk_time("R4 23:59:59 wrap", 0, 0, 0);
    set_watch(5, 59, 59);
    tk(0, "R4 pulse");
    chk_time("R4 hour carry", 6, 0, 0);

    // R5 out-of-range watch values roll to zero
    set_watch(2, 0, 62);
    tk(0, "R5 pulse");
    chk_time("R5 sec 62 wrap", 2, 1, 0);
    set_watch(31, 59, 59);
    tk(0, "R5 pulse");
    chk_time("R5 hr 31 wrap", 0, 0, 0);

    // R8 alarm fires once
    do_reset();
    wr(3'd5, 0); wr(3'd4, 0); wr(3'd3, 3);
    @(negedge clk);
    check("R7 armed 00:00:03", alarm_armed, 1);
    tk(0, "R8 tick1");
    tk(0, "R8 tick2");
    tk(1, "R8 match pulse");
    @(negedge clk);
    check("R8 pulse one cycle", alarm_pulse, 0);

    // R9 write wins over tick
    wr(3'd3, 5);
    set_watch(0, 0, 3);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'd10;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    check("R9 write kept", tod_sec, 10);
    check("R9 no pulse", alarm_pulse, 0);
    wr(3'd3, 11);
    tk(1, "R9 next tick matches");

    // R10 direct write to alarm time
    wr(3'd3, 20);
    wr(3'd0, 20);
    check("R10 no pulse on write", alarm_pulse, 0);
    @(negedge clk);
    check("R10 no pulse after write", alarm_pulse, 0);
    tk(0, "R10 moved past");
    check("R10 sec", tod_sec, 21);

    // R7 range decode
    do_reset();
    wr(3'd5, 24); wr(3'd4, 0); wr(3'd3, 1);
    @(negedge clk);
    check("R7 24:00:01 disarmed", alarm_armed, 0);
    set_watch(24, 0, 0);
    tk(0, "R7 disarmed match gives no pulse");
    chk_time("R7 watch", 24, 0, 1);
    wr(3'd3, 0);
    @(negedge clk);
    check("R7 24:00:00 armed", alarm_armed, 1);
    wr(3'd5, 23); wr(3'd4, 63);
    @(negedge clk);
    check("R7 23:63:00 armed", alarm_armed, 1);
    wr(3'd5, 25);
    @(negedge clk);
    check("R7 25:63:00 disarmed", alarm_armed, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule